// File: doc/BRIEF.md
# Timer Compare/Capture Channel

One counter channel with a free-running up-counter and two general registers, A and C. Each general register has its own 4-bit mode field. The mode field makes the register an output-compare register or an input-capture register. As an output-compare register it watches the counter. On a match it drives its own compare pin low, drives it high or toggles it, and the pin takes a chosen starting level when the mode is written. As an input-capture register it stores the counter value. The trigger is a synchronized edge on its own capture pin or a count pulse from a neighbouring channel.

A buffer bit pairs the two registers. While the bit is set, register C stops comparing and capturing on its own and serves as a staging register for A. On each compare match of A, C is loaded into A. On each capture into A, the old value of A is first pushed into C. Software reaches every register through a simple write port and a combinational read port.

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset both mode fields and the buffer bit are 0, the counter and both general registers are 0, both compare pins are low and both flags are clear.
- R2: The counter (address 0) increases by one, wrapping from all ones to 0, on every clock where `cnt_en_i` is high, and holds otherwise. A write to address 0 loads it.
- R3: Writing a mode sets that register's pin level in the same clock. Modes 0001, 0010 and 0011 give 0. Modes 0101, 0110 and 0111 give 1. Modes 0000 and 0100 and every capture mode (bit 3 set) hold the pin low.
- R4: In a compare mode (bit 3 clear), a match occurs when `cnt_en_i` is high and the counter equals the register. A match sets the register's flag. It then applies the action given by mode bits 1:0: 01 drives 0, 10 drives 1, 11 toggles, and 00 leaves the pin low.
- R5: Mode 1000 captures on a rising edge of the register's capture pin, mode 1001 on a falling edge, and modes 1010 and 1011 on both edges. The pin first passes a two-flop synchronizer. A capture loads the counter value into the register and sets its flag.
- R6: Modes 11xx capture on every clock where `nbr_cnt_pulse_i` is high instead of on a pin edge.
- R7: Registers A and C have independent mode fields with the same encoding. Each drives only its own compare pin and samples only its own capture pin.
- R8: While the buffer bit (control bit 8) is set, register C produces no compare match and no capture, whatever its mode.
- R9: While the buffer bit is set and A is in a compare mode, a compare match on A copies register C into register A.
- R10: While the buffer bit is set and A is in a capture mode, each capture into A moves the old value of A into register C.
- R11: Flags are read at address 4, bit 0 for A and bit 1 for C. Writing 0 to a bit clears it and writing 1 leaves it unchanged. A hardware set in the same clock wins over a clear.
- R12: The address map is: 0 counter, 1 register A, 2 register C, 3 control (bits 3:0 mode A, bits 7:4 mode C, bit 8 buffer), 4 flags. The read data for `rd_addr_i` is presented combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | CNT_W | Read data |
| cnt_en_i | input | 1 | Prescaled count enable |
| cap_pin_a_i | input | 1 | Capture pin for register A (asynchronous) |
| cap_pin_c_i | input | 1 | Capture pin for register C (asynchronous) |
| nbr_cnt_pulse_i | input | 1 | Count pulse from the neighbouring channel |
| cmp_pin_a_o | output | 1 | Compare pin of register A |
| cmp_pin_c_o | output | 1 | Compare pin of register C |
| flag_a_o | output | 1 | Compare/capture flag of register A |
| flag_c_o | output | 1 | Compare/capture flag of register C |

## Verification
The properties assume that `nbr_cnt_pulse_i` and `cnt_en_i` are synchronous to the clock. They also assume that software never writes the flag register with a 1 expecting to set a flag, so a flag can only rise through hardware. The stimulus changes every input only on the falling clock edge. It keeps `cnt_en_i` low while capture edges travel through the synchronizer, so each expected capture value is the counter value loaded just before. It holds each capture pin level for several clocks, so every edge is seen exactly once.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
   localparam int ADDR_W  = 3;
   localparam int MODE_W  = 4;
   localparam int NUM_GR  = 2;
   localparam int BUF_BIT = 2 * MODE_W;

   localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_GRA  = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_GRC  = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_FLAG = 3'd4;

   typedef struct packed {
      logic       is_cap;
      logic       out_en;
      logic       init_lvl;
      logic [1:0] act;
      logic       use_nbr;
      logic       both;
      logic       falling;
   } mode_dec_t;

   function automatic mode_dec_t decode_mode(logic [MODE_W-1:0] m);
      mode_dec_t d;
      d.is_cap   = m[3];
      d.out_en   = !m[3] && (m[1:0] != 2'b00);
      d.init_lvl = m[2];
      d.act      = m[1:0];
      d.use_nbr  = m[3] && m[2];
      d.both     = m[1];
      d.falling  = m[0];
      return d;
   endfunction
endpackage

// File: rtl/tmr_cc_edge_det.sv
module tmr_cc_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_cc_edge_det: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o =  sync_q[STAGES-1] && !prev_q;
   assign fall_o = !sync_q[STAGES-1] &&  prev_q;
endmodule

// File: rtl/tmr_cc_gr_unit.sv
module tmr_cc_gr_unit
   import tmr_cc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              mode_wr_i,
   input  logic [MODE_W-1:0] mode_new_i,
   input  logic              suppress_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              cnt_en_i,
   input  logic              pin_i,
   input  logic              nbr_i,
   input  logic              reg_wr_i,
   input  logic [CNT_W-1:0]  reg_wdata_i,
   input  logic              alt_ld_i,
   input  logic [CNT_W-1:0]  alt_data_i,
   input  logic              flag_clr_i,
   output logic [CNT_W-1:0]  reg_o,
   output logic              pin_o,
   output logic              flag_o,
   output logic              match_o,
   output logic              cap_o
);
   mode_dec_t        dec, dec_new;
   logic             rise, fall, trig;
   logic [CNT_W-1:0] reg_q;
   logic             pin_q, flag_q;

   tmr_cc_edge_det #(.STAGES(SYNC_STAGES)) edge_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_i),
      .rise_o(rise),
      .fall_o(fall)
   );

   always_comb begin
      dec     = decode_mode(mode_i);
      dec_new = decode_mode(mode_new_i);
      if (dec.use_nbr)   trig = nbr_i;
      else if (dec.both) trig = rise || fall;
      else               trig = dec.falling ? fall : rise;
   end

   assign match_o = !suppress_i && !dec.is_cap && cnt_en_i && (cnt_i == reg_q);
   assign cap_o   = !suppress_i &&  dec.is_cap && trig;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reg_q  <= '0;
         pin_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (reg_wr_i)      reg_q <= reg_wdata_i;
         else if (cap_o)    reg_q <= cnt_i;
         else if (alt_ld_i) reg_q <= alt_data_i;

         if (match_o || cap_o) flag_q <= 1'b1;
         else if (flag_clr_i)  flag_q <= 1'b0;

         if (mode_wr_i) begin
            pin_q <= dec_new.out_en && dec_new.init_lvl;
         end else if (match_o && dec.out_en) begin
            case (dec.act)
               2'b01:   pin_q <= 1'b0;
               2'b10:   pin_q <= 1'b1;
               default: pin_q <= !pin_q;
            endcase
         end
      end
   end

   assign reg_o  = reg_q;
   assign pin_o  = pin_q && dec.out_en;
   assign flag_o = flag_q;
endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
   import tmr_cc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   input  logic [2:0]        rd_addr_i,
   output logic [CNT_W-1:0]  rd_data_o,
   input  logic              cnt_en_i,
   input  logic              cap_pin_a_i,
   input  logic              cap_pin_c_i,
   input  logic              nbr_cnt_pulse_i,
   output logic              cmp_pin_a_o,
   output logic              cmp_pin_c_o,
   output logic              flag_a_o,
   output logic              flag_c_o
);
   localparam int CTRL_W = BUF_BIT + 1;

   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("tmr_cc_channel: CNT_W too narrow for control register");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic              buf_q;
   logic [MODE_W-1:0] mode_q   [NUM_GR];
   logic [CNT_W-1:0]  gr_q     [NUM_GR];
   logic              match    [NUM_GR];
   logic              cap      [NUM_GR];
   logic              pin      [NUM_GR];
   logic              flag     [NUM_GR];
   logic              alt_ld   [NUM_GR];
   logic [CNT_W-1:0]  alt_data [NUM_GR];
   logic              suppress [NUM_GR];
   logic              cap_pin  [NUM_GR];
   logic              ctrl_wr, flag_wr;

   assign ctrl_wr = wr_en_i && (wr_addr_i == ADR_CTRL);
   assign flag_wr = wr_en_i && (wr_addr_i == ADR_FLAG);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         buf_q <= 1'b0;
      end else begin
         if (wr_en_i && (wr_addr_i == ADR_CNT)) cnt_q <= wr_data_i;
         else if (cnt_en_i)                     cnt_q <= cnt_q + 1'b1;
         if (ctrl_wr) buf_q <= wr_data_i[BUF_BIT];
      end
   end

   // Buffer pairing: A reloads from C on match, C takes old A on capture.
   assign alt_ld[0]   = buf_q && match[0];
   assign alt_data[0] = gr_q[1];
   assign alt_ld[1]   = buf_q && cap[0];
   assign alt_data[1] = gr_q[0];
   assign suppress[0] = 1'b0;
   assign suppress[1] = buf_q;
   assign cap_pin[0]  = cap_pin_a_i;
   assign cap_pin[1]  = cap_pin_c_i;

   for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
      logic [MODE_W-1:0] mode_new;
      assign mode_new = wr_data_i[g*MODE_W +: MODE_W];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      mode_q[g] <= '0;
         else if (ctrl_wr) mode_q[g] <= mode_new;
      end

      tmr_cc_gr_unit #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) unit_i (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .mode_i     (mode_q[g]),
         .mode_wr_i  (ctrl_wr),
         .mode_new_i (mode_new),
         .suppress_i (suppress[g]),
         .cnt_i      (cnt_q),
         .cnt_en_i   (cnt_en_i),
         .pin_i      (cap_pin[g]),
         .nbr_i      (nbr_cnt_pulse_i),
         .reg_wr_i   (wr_en_i && (wr_addr_i == ((g == 0) ? ADR_GRA : ADR_GRC))),
         .reg_wdata_i(wr_data_i),
         .alt_ld_i   (alt_ld[g]),
         .alt_data_i (alt_data[g]),
         .flag_clr_i (flag_wr && !wr_data_i[g]),
         .reg_o      (gr_q[g]),
         .pin_o      (pin[g]),
         .flag_o     (flag[g]),
         .match_o    (match[g]),
         .cap_o      (cap[g])
      );
   end

   assign cmp_pin_a_o = pin[0];
   assign cmp_pin_c_o = pin[1];
   assign flag_a_o    = flag[0];
   assign flag_c_o    = flag[1];

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         ADR_CNT:  rd_data_o = cnt_q;
         ADR_GRA:  rd_data_o = gr_q[0];
         ADR_GRC:  rd_data_o = gr_q[1];
         ADR_CTRL: rd_data_o[CTRL_W-1:0] = {buf_q, mode_q[1], mode_q[0]};
         ADR_FLAG: rd_data_o[1:0] = {flag[1], flag[0]};
         default:  rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/tmr_cc_channel_chk.sv
module tmr_cc_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             wr_en_i,
   input logic [2:0]       wr_addr_i,
   input logic             cnt_en_i,
   input logic             nbr_cnt_pulse_i,
   input logic             cmp_pin_a_o,
   input logic             flag_a_o,
   input logic             flag_c_o,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reg_a,
   input logic [CNT_W-1:0] reg_c,
   input logic [3:0]       mode_a,
   input logic             buf_en
);
   logic wr_cnt, wr_a, wr_ctrl, hit_a;
   assign wr_cnt  = wr_en_i && (wr_addr_i == 3'd0);
   assign wr_a    = wr_en_i && (wr_addr_i == 3'd1);
   assign wr_ctrl = wr_en_i && (wr_addr_i == 3'd3);
   assign hit_a   = !mode_a[3] && cnt_en_i && (cnt == reg_a);

   p_cnt_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_en_i && !wr_cnt) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cnt_en_i && !wr_cnt) |=> $stable(cnt));

   p_cmp_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_a |=> flag_a_o);

   p_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_a && mode_a == 4'b0011 && !wr_ctrl) |=> (cmp_pin_a_o != $past(cmp_pin_a_o)));

   p_nbr_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_a[3:2] == 2'b11 && nbr_cnt_pulse_i && !wr_a) |=> (reg_a == $past(cnt)));

   p_buf_c_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (buf_en && !flag_c_o) |=> !flag_c_o);

   p_buf_copy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (buf_en && hit_a && !wr_a) |=> (reg_a == $past(reg_c)));
endmodule

bind tmr_cc_channel tmr_cc_channel_chk #(.CNT_W(CNT_W)) chk_i (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .wr_en_i        (wr_en_i),
   .wr_addr_i      (wr_addr_i),
   .cnt_en_i       (cnt_en_i),
   .nbr_cnt_pulse_i(nbr_cnt_pulse_i),
   .cmp_pin_a_o    (cmp_pin_a_o),
   .flag_a_o       (flag_a_o),
   .flag_c_o       (flag_c_o),
   .cnt            (cnt_q),
   .reg_a          (gr_q[0]),
   .reg_c          (gr_q[1]),
   .mode_a         (mode_q[0]),
   .buf_en         (buf_q)
);

// File: tb/tmr_cc_channel_tb_top.sv
`timescale 1ns/1ps
module tmr_cc_channel_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [2:0]   rd_addr = '0;
   logic [W-1:0] rd_data;
   logic         cnt_en = 1'b0;
   logic         pin_a = 1'b0, pin_c = 1'b0, nbr = 1'b0;
   logic         cmp_a, cmp_c, flg_a, flg_c;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tmr_cc_channel #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .cnt_en_i(cnt_en), .cap_pin_a_i(pin_a), .cap_pin_c_i(pin_c),
      .nbr_cnt_pulse_i(nbr),
      .cmp_pin_a_o(cmp_a), .cmp_pin_c_o(cmp_c),
      .flag_a_o(flg_a), .flag_c_o(flg_c)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic run(input int n);
      @(negedge clk);
      cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(3'd3, v); chk("R1 ctrl", v, 0);
      rd(3'd0, v); chk("R1 cnt", v, 0);
      rd(3'd1, v); chk("R1 regA", v, 0);
      rd(3'd2, v); chk("R1 regC", v, 0);
      chk("R1 pins", {cmp_a, cmp_c}, 0);
      chk("R1 flags", {flg_a, flg_c}, 0);

      // R2 counting, wrap and hold
      wr(3'd0, 16'hFFFE);
      run(3);
      rd(3'd0, v); chk("R2 wrap", v, 16'h0001);
      idle(3);
      rd(3'd0, v); chk("R2 hold", v, 16'h0001);

      // R3/R4 compare modes sweep on A
      for (int m = 0; m < 8; m++) begin
         logic oe, init, fin;
         oe   = (m[1:0] != 2'b00);
         init = oe && m[2];
         case (m[1:0])
            2'b01:   fin = 1'b0;
            2'b10:   fin = 1'b1;
            2'b11:   fin = !init;
            default: fin = 1'b0;
         endcase
         wr(3'd4, 16'h0);
         wr(3'd3, 16'(m));
         #1 chk($sformatf("R3 init level mode %0d", m), cmp_a, init);
         wr(3'd0, 16'd5);
         wr(3'd1, 16'd6);
         run(1);
         #1 chk($sformatf("R4 no early match mode %0d", m), flg_a, 0);
         run(1);
         #1 chk($sformatf("R4 pin after match mode %0d", m), cmp_a, fin);
         chk($sformatf("R4 flag mode %0d", m), flg_a, 1);
         chk($sformatf("R7 C untouched mode %0d", m), {cmp_c, flg_c}, 0);
      end
      // R4 no match when count enable low
      wr(3'd4, 16'h0);
      wr(3'd0, 16'd6);
      idle(3);
      chk("R4 no match without enable", flg_a, 0);

      // R11 flag clear semantics
      wr(3'd3, 16'h0003);
      wr(3'd2, 16'd9);
      wr(3'd3, 16'h0031);
      wr(3'd0, 16'd6);
      run(1);
      wr(3'd0, 16'd9);
      run(1);
      chk("R11 both flags set", {flg_c, flg_a}, 2'b11);
      wr(3'd4, 16'h0001);
      #1 chk("R11 write 1 keeps, 0 clears", {flg_c, flg_a}, 2'b01);
      wr(3'd4, 16'h0000);
      #1 chk("R11 clear A", flg_a, 0);

      // R5/R6 capture modes sweep on A
      for (int m = 8; m < 16; m++) begin
         logic cr, cf, cn;
         cr = (m == 8) || (m == 10) || (m == 11);
         cf = (m == 9) || (m == 10) || (m == 11);
         cn = (m >= 12);
         wr(3'd3, 16'(m));
         #1 chk($sformatf("R3 pin low capture mode %0d", m), cmp_a, 0);
         wr(3'd4, 16'h0); wr(3'd1, 16'h0); wr(3'd0, 16'h1200 + 16'(m));
         @(negedge clk); pin_a = 1'b1;
         idle(4);
         rd(3'd1, v); chk($sformatf("R5 rise capture mode %0d", m), v, cr ? 16'h1200 + 16'(m) : 16'h0);
         chk($sformatf("R5 rise flag mode %0d", m), flg_a, cr);
         wr(3'd4, 16'h0); wr(3'd1, 16'h0); wr(3'd0, 16'h3400 + 16'(m));
         @(negedge clk); pin_a = 1'b0;
         idle(4);
         rd(3'd1, v); chk($sformatf("R5 fall capture mode %0d", m), v, cf ? 16'h3400 + 16'(m) : 16'h0);
         chk($sformatf("R5 fall flag mode %0d", m), flg_a, cf);
         wr(3'd4, 16'h0); wr(3'd1, 16'h0); wr(3'd0, 16'h5600 + 16'(m));
         @(negedge clk); nbr = 1'b1;
         @(negedge clk); nbr = 1'b0;
         rd(3'd1, v); chk($sformatf("R6 pulse capture mode %0d", m), v, cn ? 16'h5600 + 16'(m) : 16'h0);
         chk($sformatf("R6 pulse flag mode %0d", m), flg_a, cn);
      end

      // R7 independent C output
      wr(3'd4, 16'h0);
      wr(3'd3, 16'h0050);
      #1 chk("R7 C init high, A low", {cmp_c, cmp_a}, 2'b10);
      wr(3'd1, 16'h0100);
      wr(3'd2, 16'h0020);
      wr(3'd0, 16'h001F);
      run(2);
      chk("R7 C drives 0 on match", cmp_c, 0);
      chk("R7 flags C only", {flg_c, flg_a}, 2'b10);

      // R9 buffered compare, R8 C suppressed
      wr(3'd4, 16'h0);
      wr(3'd3, 16'h0123);
      wr(3'd1, 16'd3);
      wr(3'd2, 16'd9);
      wr(3'd0, 16'd2);
      run(2);
      rd(3'd1, v); chk("R9 A reloaded from C", v, 16'd9);
      chk("R9 A toggled", cmp_a, 1);
      chk("R9 flag A", flg_a, 1);
      wr(3'd1, 16'd100);
      wr(3'd0, 16'd8);
      run(2);
      chk("R8 no C match in buffer mode", {flg_c, cmp_c}, 2'b00);

      // R10 buffered capture, R8 C capture suppressed
      wr(3'd4, 16'h0);
      wr(3'd3, 16'h0188);
      wr(3'd1, 16'h0011);
      wr(3'd2, 16'h0022);
      wr(3'd0, 16'h0055);
      @(negedge clk); pin_a = 1'b1;
      idle(4);
      rd(3'd1, v); chk("R10 A captured", v, 16'h0055);
      rd(3'd2, v); chk("R10 old A pushed to C", v, 16'h0011);
      wr(3'd0, 16'h0066);
      @(negedge clk); pin_c = 1'b1;
      idle(4);
      rd(3'd2, v); chk("R8 no C capture in buffer mode", v, 16'h0011);
      chk("R8 flag C clear", flg_c, 0);
      rd(3'd3, v); chk("R12 control readback", v, 16'h0188);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule